// File: doc/BRIEF.md
# LIN Bus Error Status Monitor

This block gathers the error and event flags of a LIN controller and holds them until software clears them. A stuck-dominant detector watches the receive line on each bit-time tick. If the line stays dominant too long, the detector raises a flag, and it raises the flag again at a fixed interval for as long as the line stays low. One-cycle error pulses from the header and response logic are latched into sticky flags. These pulses cover bit error, checksum mismatch, sync inconsistency, short break delimiter and identifier parity. A checksum pulse is dropped while checksum checking is turned off.

An 8-bit counter advances on a count tick. When it steps onto either of two programmed values, it sets a compare flag. That flag can request a return to idle, and in timeout mode hardware clears it while the controller is in initialization. Software reads a 32-bit status word and clears flags by writing ones. A header-error interrupt is raised from the three header flags.

The stuck-dominant detector is a three-state machine with these states:
- `SD_IDLE`: the line was last sampled recessive.
- `SD_FIRST`: counting toward the first detection.
- `SD_REPEAT`: counting toward each repeat detection.

It has these transitions:
- Idle→First on a dominant sample.
- First→Repeat when it fires.
- Repeat→Repeat when it fires again.
- Any state→Idle on a recessive sample.

Top module: `lin_err_monitor`

## Requirements
- R1: Status bit 0 (stuck-dominant) sets on the 101st consecutive dominant (`rx_in`=0) sample taken on `bit_tick`, and not before.
- R2: While the line stays dominant after a detection, bit 0 sets again on every further 87th dominant sample. A single recessive sample restarts the count from zero.
- R3: Writing a one to a status bit while `clr_we` is high clears that flag. Writing zero leaves it unchanged. A hardware set in the same cycle as a software clear leaves the flag set.
- R4: Status bit 1 (compare) sets in the cycle the counter steps onto `cmp_val_a` or `cmp_val_b`. The counter resets to 0 and increments once per `cnt_tick`.
- R5: With `cfg_timeout_mode`=1, status bit 1 is cleared while `init_mode` is high. With `cfg_timeout_mode`=0, `init_mode` has no effect on it.
- R6: `idle_req` is high exactly when status bit 1 is set and `cfg_idle_on_to` is high.
- R7: Status bit 3 (checksum) sets on `evt_chk_err` only when both `cfg_chk_calc_dis` and `cfg_chk_field_dis` are low.
- R8: Error pulses latch into fixed status bits: bit error to bit 2, sync error to bit 4, short delimiter to bit 5, identifier parity to bit 6.
- R9: `hdr_irq` is high exactly when `cfg_hdr_irq_en` is high and any of status bits 4, 5 or 6 is set.
- R10: After reset all flags and the counter are zero. Status bits 31..7 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One pulse per bit time, sampling strobe for `rx_in` |
| rx_in | input | 1 | Receive line, 0 = dominant |
| cnt_tick | input | 1 | Advance the 8-bit compare counter |
| cmp_val_a | input | 8 | First compare value |
| cmp_val_b | input | 8 | Second compare value |
| init_mode | input | 1 | Controller is in initialization |
| cfg_timeout_mode | input | 1 | Hardware clears compare flag during initialization |
| cfg_idle_on_to | input | 1 | Compare flag requests idle |
| cfg_hdr_irq_en | input | 1 | Header-error interrupt enable |
| cfg_chk_calc_dis | input | 1 | Checksum calculation disabled |
| cfg_chk_field_dis | input | 1 | Checksum field disabled |
| evt_bit_err | input | 1 | Bit error pulse |
| evt_chk_err | input | 1 | Checksum mismatch pulse |
| evt_sync_err | input | 1 | Sync field error pulse |
| evt_delim_short | input | 1 | Break delimiter shorter than one bit pulse |
| evt_id_parity | input | 1 | Identifier parity error pulse |
| clr_we | input | 1 | Software clear strobe |
| clr_data | input | 32 | Write-one-to-clear mask |
| status | output | 32 | Flag status word |
| hdr_irq | output | 1 | Header-error interrupt |
| idle_req | output | 1 | Request to enter idle |

## Verification
The repeat detection is the hardest case to reach from the ports. It appears only after an unbroken run of 101 dominant samples followed by exactly 87 more. The flag must also be cleared between the two runs, or the second detection cannot be seen. The stimulus therefore strobes `bit_tick` every clock with `rx_in` low. It clears bit 0 in a cycle without a tick, so the count is not disturbed. It then checks the sample just before each boundary as well as the boundary itself. A single recessive sample is then inserted, and the full first-detection window is run again to show that the count restarted.

// File: rtl/lin_err_pkg.sv
package lin_err_pkg;
    typedef enum logic [1:0] {
        SD_IDLE   = 2'd0,
        SD_FIRST  = 2'd1,
        SD_REPEAT = 2'd2
    } dom_state_e;

    localparam int NFLAG     = 7;
    localparam int FL_STUCK  = 0;
    localparam int FL_CMP    = 1;
    localparam int FL_BIT    = 2;
    localparam int FL_CHK    = 3;
    localparam int FL_SYNC   = 4;
    localparam int FL_DELIM  = 5;
    localparam int FL_IDPAR  = 6;
endpackage

// File: rtl/lin_dom_watch.sv
module lin_dom_watch
    import lin_err_pkg::*;
#(
    parameter int FIRST_BITS  = 100,
    parameter int REPEAT_BITS = 87
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic rx_in,
    output logic fire
);
    localparam int CW = $clog2(FIRST_BITS + 1);

    dom_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SD_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (bit_tick) begin
            if (rx_in) begin
                state_d = SD_IDLE;
                cnt_d   = '0;
            end else begin
                unique case (state_q)
                    SD_IDLE: begin
                        state_d = SD_FIRST;
                        cnt_d   = CW'(1);
                    end
                    SD_FIRST: begin
                        if (cnt_q == CW'(FIRST_BITS)) begin
                            fire    = 1'b1;
                            state_d = SD_REPEAT;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                    SD_REPEAT: begin
                        if (cnt_q == CW'(REPEAT_BITS - 1)) begin
                            fire  = 1'b1;
                            cnt_d = '0;
                        end else begin
                            cnt_d = cnt_q + CW'(1);
                        end
                    end
                    default: begin
                        state_d = SD_IDLE;
                        cnt_d   = '0;
                    end
                endcase
            end
        end
    end

    AST_FIRE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (state_q != SD_IDLE && !rx_in));                           // R1
    AST_RECESSIVE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && rx_in) |=> (cnt_q == '0 && state_q == SD_IDLE));       // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(FIRST_BITS));                                          // R2
endmodule

// File: rtl/lin_cmp_timer.sv
module lin_cmp_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic             match
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    assign cnt_nx = cnt_q + CNT_W'(1);
    assign match  = cnt_tick && ((cnt_nx == cmp_a) || (cnt_nx == cmp_b));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (cnt_tick) cnt_q <= cnt_nx;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));                  // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(cnt_q));                                      // R4
endmodule

// File: rtl/lin_flag_bank.sv
module lin_flag_bank #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] hw_clr,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic wclr;
        assign wclr = clr_we && clr_mask[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         flags[i] <= 1'b0;
            else if (hw_clr[i]) flags[i] <= 1'b0;
            else if (hw_set[i]) flags[i] <= 1'b1;
            else if (wclr)      flags[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_set[i] && !hw_clr[i]) |=> flags[i]);                        // R3
        AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (wclr && !hw_set[i]) |=> !flags[i]);                            // R3
        AST_W0_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !wclr && !hw_clr[i]) |=> flags[i]);                // R3
    end
endmodule

// File: rtl/lin_err_monitor.sv
module lin_err_monitor
    import lin_err_pkg::*;
#(
    parameter int FIRST_BITS  = 100,
    parameter int REPEAT_BITS = 87,
    parameter int CNT_W       = 8,
    parameter int STAT_W      = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              rx_in,
    input  logic              cnt_tick,
    input  logic [CNT_W-1:0]  cmp_val_a,
    input  logic [CNT_W-1:0]  cmp_val_b,
    input  logic              init_mode,
    input  logic              cfg_timeout_mode,
    input  logic              cfg_idle_on_to,
    input  logic              cfg_hdr_irq_en,
    input  logic              cfg_chk_calc_dis,
    input  logic              cfg_chk_field_dis,
    input  logic              evt_bit_err,
    input  logic              evt_chk_err,
    input  logic              evt_sync_err,
    input  logic              evt_delim_short,
    input  logic              evt_id_parity,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_data,
    output logic [STAT_W-1:0] status,
    output logic              hdr_irq,
    output logic              idle_req
);
    localparam int PAD_W = STAT_W - NFLAG;

    logic             stuck_fire;
    logic             cmp_match;
    logic [NFLAG-1:0] set_vec;
    logic [NFLAG-1:0] hwclr_vec;
    logic [NFLAG-1:0] flags;

    lin_dom_watch #(.FIRST_BITS(FIRST_BITS), .REPEAT_BITS(REPEAT_BITS)) u_dom (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in),
        .fire(stuck_fire)
    );

    lin_cmp_timer #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
        .cmp_a(cmp_val_a), .cmp_b(cmp_val_b), .match(cmp_match)
    );

    always_comb begin
        set_vec            = '0;
        set_vec[FL_STUCK]  = stuck_fire;
        set_vec[FL_CMP]    = cmp_match;
        set_vec[FL_BIT]    = evt_bit_err;
        set_vec[FL_CHK]    = evt_chk_err && !cfg_chk_calc_dis && !cfg_chk_field_dis;
        set_vec[FL_SYNC]   = evt_sync_err;
        set_vec[FL_DELIM]  = evt_delim_short;
        set_vec[FL_IDPAR]  = evt_id_parity;
        hwclr_vec          = '0;
        hwclr_vec[FL_CMP]  = cfg_timeout_mode && init_mode;
    end

    lin_flag_bank #(.N(NFLAG)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(set_vec), .hw_clr(hwclr_vec),
        .clr_we(clr_we), .clr_mask(clr_data[NFLAG-1:0]), .flags(flags)
    );

    assign status   = {{PAD_W{1'b0}}, flags};
    assign hdr_irq  = cfg_hdr_irq_en && (flags[FL_SYNC] || flags[FL_DELIM] || flags[FL_IDPAR]);
    assign idle_req = flags[FL_CMP] && cfg_idle_on_to;

    AST_CHK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!status[FL_CHK] && (cfg_chk_calc_dis || cfg_chk_field_dis)) |=> !status[FL_CHK]); // R7
    AST_CMP_INIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout_mode && init_mode) |=> !status[FL_CMP]);                             // R5
    AST_BIT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bit_err |=> status[FL_BIT]);                                                  // R8
endmodule

// File: tb/lin_err_monitor_tb.sv
`timescale 1ns/1ps
module lin_err_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_tick = 0, rx_in = 1, cnt_tick = 0;
    logic [7:0]  cmp_val_a = 8'd200, cmp_val_b = 8'd201;
    logic        init_mode = 0, cfg_timeout_mode = 0, cfg_idle_on_to = 0;
    logic        cfg_hdr_irq_en = 0, cfg_chk_calc_dis = 0, cfg_chk_field_dis = 0;
    logic        evt_bit_err = 0, evt_chk_err = 0, evt_sync_err = 0;
    logic        evt_delim_short = 0, evt_id_parity = 0;
    logic        clr_we = 0;
    logic [31:0] clr_data = '0;
    logic [31:0] status;
    logic        hdr_irq, idle_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] st;
        logic        irq;
        logic        idl;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    lin_err_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_in(rx_in),
        .cnt_tick(cnt_tick), .cmp_val_a(cmp_val_a), .cmp_val_b(cmp_val_b),
        .init_mode(init_mode), .cfg_timeout_mode(cfg_timeout_mode),
        .cfg_idle_on_to(cfg_idle_on_to), .cfg_hdr_irq_en(cfg_hdr_irq_en),
        .cfg_chk_calc_dis(cfg_chk_calc_dis), .cfg_chk_field_dis(cfg_chk_field_dis),
        .evt_bit_err(evt_bit_err), .evt_chk_err(evt_chk_err),
        .evt_sync_err(evt_sync_err), .evt_delim_short(evt_delim_short),
        .evt_id_parity(evt_id_parity), .clr_we(clr_we), .clr_data(clr_data),
        .status(status), .hdr_irq(hdr_irq), .idle_req(idle_req)
    );

    // monitor: compare at falling edge
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (status !== e.st || hdr_irq !== e.irq || idle_req !== e.idl) begin
                    errors++;
                    $display("FAIL %s: status=%h irq=%b idle=%b expected status=%h irq=%b idle=%b",
                             e.tag, status, hdr_irq, idle_req, e.st, e.irq, e.idl);
                end
            end
        end
    end

    task automatic push(input logic [31:0] st, input logic irq, input logic idl, input string tag);
        exp_t e;
        e.st = st; e.irq = irq; e.idl = idl; e.tag = tag;
        sb.push_back(e);
    endtask

    // one clock with current inputs, then drop pulses
    task automatic step();
        @(posedge clk); #1;
        bit_tick = 0; cnt_tick = 0; clr_we = 0; clr_data = '0;
        evt_bit_err = 0; evt_chk_err = 0; evt_sync_err = 0;
        evt_delim_short = 0; evt_id_parity = 0;
    endtask

    task automatic ticks(input int n, input logic lvl);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1; rx_in = lvl; step();
        end
    endtask

    task automatic clear(input logic [31:0] m);
        @(negedge clk); clr_we = 1; clr_data = m; step();
    endtask

    task automatic counts(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_tick = 1; step();
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        push(32'h0, 0, 0, "R10 reset");

        // R1 first detection
        ticks(100, 1'b0);
        push(32'h0, 0, 0, "R1 100 dominant");
        ticks(1, 1'b0);
        push(32'h1, 0, 0, "R1 101st dominant");
        clear(32'h1);
        push(32'h0, 0, 0, "R3 clear stuck");
        // R2 repeat
        ticks(86, 1'b0);
        push(32'h0, 0, 0, "R2 86 more");
        ticks(1, 1'b0);
        push(32'h1, 0, 0, "R2 87th more");
        clear(32'h1);
        ticks(1, 1'b1);
        ticks(100, 1'b0);
        push(32'h0, 0, 0, "R2 restart after recessive");
        ticks(1, 1'b0);
        push(32'h1, 0, 0, "R2 restart fires at 101");
        clear(32'hFFFF_FFFF);
        ticks(1, 1'b1);
        push(32'h0, 0, 0, "R3 clear all");

        // R8 / R3 write-zero and set-wins
        @(negedge clk); evt_bit_err = 1; step();
        push(32'h4, 0, 0, "R8 bit error bit2");
        clear(32'hFFFF_FFFB);
        push(32'h4, 0, 0, "R3 write zero holds");
        @(negedge clk); evt_bit_err = 1; clr_we = 1; clr_data = 32'h4; step();
        push(32'h4, 0, 0, "R3 set wins");
        clear(32'h4);
        push(32'h0, 0, 0, "R3 clear bit2");

        // R8 / R9 header flags
        @(negedge clk); evt_sync_err = 1; evt_delim_short = 1; evt_id_parity = 1; step();
        push(32'h70, 0, 0, "R8 header flags, R9 irq disabled");
        @(negedge clk); cfg_hdr_irq_en = 1; step();
        push(32'h70, 1, 0, "R9 irq enabled");
        clear(32'h10);
        push(32'h60, 1, 0, "R9 irq after sync cleared");
        clear(32'h60);
        push(32'h0, 0, 0, "R9 irq drops");
        @(negedge clk); evt_bit_err = 1; step();
        push(32'h4, 0, 0, "R9 bit error no irq");
        clear(32'h4);

        // R7 checksum gating
        @(negedge clk); cfg_chk_calc_dis = 1; evt_chk_err = 1; step();
        push(32'h0, 0, 0, "R7 calc disabled");
        @(negedge clk); cfg_chk_calc_dis = 0; cfg_chk_field_dis = 1; evt_chk_err = 1; step();
        push(32'h0, 0, 0, "R7 field disabled");
        @(negedge clk); cfg_chk_field_dis = 0; evt_chk_err = 1; step();
        push(32'h8, 0, 0, "R7 checksum set");
        clear(32'h8);

        // R4 / R5 / R6 compare
        @(negedge clk); cmp_val_a = 8'd3; cmp_val_b = 8'd6; step();
        counts(2);
        push(32'h0, 0, 0, "R4 counter at 2");
        counts(1);
        push(32'h2, 0, 0, "R4 match A");
        @(negedge clk); cfg_idle_on_to = 1; step();
        push(32'h2, 0, 1, "R6 idle request");
        clear(32'h2);
        push(32'h0, 0, 0, "R6 idle drops");
        counts(2);
        push(32'h0, 0, 0, "R4 counter at 5");
        counts(1);
        push(32'h2, 0, 1, "R4 match B");
        @(negedge clk); init_mode = 1; step();
        push(32'h2, 0, 1, "R5 init without timeout mode");
        @(negedge clk); cfg_timeout_mode = 1; step();
        push(32'h0, 0, 0, "R5 init with timeout mode");
        @(negedge clk); init_mode = 0; step();
        push(32'h0, 0, 0, "R5 after init");

        repeat (3) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule